// File: doc/BRIEF.md
# Interrupt Cause Collector with Rate Moderation

This block gathers interrupt causes from the receive and transmit paths of a network controller and drives one level-sensitive interrupt line toward the host. Each cause has a sticky bit in a pending-cause register. A mask register selects which pending causes may drive the line. A throttle interval sets a minimum spacing between two assertions of the line, and a cause can be posted with an immediate flag that skips that spacing.

Four delay timers sit in front of the cause register. On the receive side there is a per-packet timer and an absolute timer. The transmit side has the same pair. When any of them runs out, the block pulses a flush request to the matching descriptor engine. That request asks for a writeback of every used descriptor with no alignment restriction. In the same cycle the block posts the matching cause, subject to the throttle. All timers count in a shared time unit of 1024 ns, which is `TICK_DIV` clock cycles.

All inputs are single-cycle strobes or plain control. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure. Every strobe is accepted in the cycle it is high.

Top module: `irq_moderator`

## Requirements
- R1: After reset the interrupt line, both flush outputs, the pending-cause register, the mask, every timer limit and the throttle interval are all zero.
- R2: A post sets the bits of `post_bits` in the pending register, ORed with the bits already set, from the next cycle on. `cause_rd_data` always shows the register. A cycle with `cause_rd` high clears it. A cause posted in that same cycle is kept.
- R3: With a zero throttle interval, the line is high exactly when the pending register ANDed with the mask is nonzero, from the cycle after the change. A mask write (`reg_sel` 5, mask in the low `NCAUSE` bits of `reg_wdata`) can therefore raise or drop the line.
- R4: A read that clears every pending cause, with no new cause in that cycle, drops the line in the next cycle.
- R5: The throttle interval is written with `reg_sel` 4, in units of `TICK_DIV` cycles. Each assertion loads it. If the interval is still running, a non-immediate cause does not raise the line. The line rises in the cycle after the interval runs out, if an unmasked cause is still pending. The spacing between two rises is therefore between (N-1)·TICK_DIV+2 and N·TICK_DIV+2 cycles.
- R6: A post with `post_now` high raises the line in the next cycle if any posted bit is unmasked, even while the throttle interval is running.
- R7: The receive per-packet timer (`reg_sel` 0, limit N) restarts on every `rx_event`. It expires between (N-1)·TICK_DIV+1 and N·TICK_DIV cycles after the last event. On expiry, `rx_wb_flush` pulses for one cycle and cause bit 7 is set.
- R8: The receive absolute timer (`reg_sel` 1) starts on the first `rx_event` and is not restarted by later ones. It expires in the same window measured from that first event, with the same flush pulse and cause bit 7.
- R9: The transmit per-packet (`reg_sel` 2) and absolute (`reg_sel` 3) timers behave in the same way on `tx_event`. They pulse `tx_wb_flush` and set cause bit 0.
- R10: A timer limit of 0 disables that timer. Writing 0 to a running timer cancels it, and no flush or cause follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | Strobe: post the causes in `post_bits` |
| post_bits | input | NCAUSE | Causes to post |
| post_now | input | 1 | Post skips the throttle interval |
| rx_event | input | 1 | Receive packet event, arms receive timers |
| tx_event | input | 1 | Transmit descriptor event, arms transmit timers |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | 0..3 timer limits, 4 throttle, 5 mask |
| reg_wdata | input | TW | Write value |
| cause_rd | input | 1 | Read-and-clear strobe for the pending register |
| cause_rd_data | output | NCAUSE | Current pending-cause register |
| irq | output | 1 | Interrupt line |
| rx_wb_flush | output | 1 | Pulse: full unaligned receive descriptor writeback |
| tx_wb_flush | output | 1 | Pulse: full unaligned transmit descriptor writeback |

## Verification
A long random run drives posts, reads and mask writes with the throttle off. Its model of the pending register and the mask catches mistakes in OR accumulation, in read/post priority and in mask re-evaluation. Directed timer cases send a second event partway through a countdown. That separates a timer that restarts from one that does not, and both from a timer whose limit is 0 or was cancelled. The throttle case times the gap between two rises against the interval window. It then posts an immediate cause while the interval runs, which shows whether the bypass works.

// File: rtl/irq_moderator_pkg.sv
package irq_moderator_pkg;
  typedef enum logic [2:0] {
    SEL_RX_PKT   = 3'd0,
    SEL_RX_ABS   = 3'd1,
    SEL_TX_PKT   = 3'd2,
    SEL_TX_ABS   = 3'd3,
    SEL_THROTTLE = 3'd4,
    SEL_MASK     = 3'd5
  } reg_sel_e;

  localparam int NUM_TIMERS = 4;
endpackage

// File: rtl/unit_prescaler.sv
module unit_prescaler #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  output logic unit_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign unit_tick = (cnt_q == LAST);
endmodule

// File: rtl/delay_timer.sv
module delay_timer #(
  parameter int TW      = 16,
  parameter bit RESTART = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unit_tick,
  input  logic [TW-1:0] limit,
  input  logic          arm,
  output logic          expire
);
  logic          active_q;
  logic [TW-1:0] rem_q;
  logic          load;

  // a per-packet cell reloads on every arm, an absolute cell only when idle
  assign load = arm && (RESTART || !active_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rem_q    <= '0;
    end else if (limit == '0) begin
      active_q <= 1'b0;
    end else if (load) begin
      active_q <= 1'b1;
      rem_q    <= limit;
    end else if (active_q && unit_tick) begin
      if (rem_q == TW'(1)) active_q <= 1'b0;
      else                 rem_q    <= rem_q - 1'b1;
    end
  end

  assign expire = active_q && unit_tick && (rem_q == TW'(1)) &&
                  (limit != '0) && !load;
endmodule

// File: rtl/irq_throttle.sv
module irq_throttle #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unit_tick,
  input  logic [TW-1:0] interval,
  input  logic          pend_next,
  input  logic          imm,
  output logic          irq
);
  logic [TW-1:0] hold_q;
  logic          busy;
  logic          irq_d;

  assign busy  = (hold_q != '0);
  assign irq_d = pend_next && (irq || imm || !busy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq    <= 1'b0;
      hold_q <= '0;
    end else begin
      irq <= irq_d;
      if (irq_d && !irq)      hold_q <= interval;
      else if (unit_tick && busy) hold_q <= hold_q - 1'b1;
    end
  end
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import irq_moderator_pkg::*;
#(
  parameter int NCAUSE   = 8,
  parameter int TW       = 16,
  parameter int TICK_DIV = 128,
  parameter int RX_CAUSE = 7,
  parameter int TX_CAUSE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_valid,
  input  logic [NCAUSE-1:0] post_bits,
  input  logic              post_now,
  input  logic              rx_event,
  input  logic              tx_event,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [TW-1:0]     reg_wdata,
  input  logic              cause_rd,
  output logic [NCAUSE-1:0] cause_rd_data,
  output logic              irq,
  output logic              rx_wb_flush,
  output logic              tx_wb_flush
);
  logic                  unit_tick;
  logic [TW-1:0]         lim_q [NUM_TIMERS];
  logic [TW-1:0]         thr_interval;
  logic [NCAUSE-1:0]     mask_q, mask_next;
  logic [NCAUSE-1:0]     cause_q, cause_next;
  logic [NCAUSE-1:0]     timer_bits, in_bits;
  logic [NUM_TIMERS-1:0] fire;
  logic                  rx_fire, tx_fire;
  logic                  pend_next;

  unit_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .unit_tick(unit_tick)
  );

  // timers 0,1 follow rx_event; 2,3 follow tx_event; even index restarts
  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    localparam bit IS_PKT = ((g % 2) == 0);
    logic arm_g;
    if (g < 2) begin : g_rx
      assign arm_g = rx_event;
    end else begin : g_tx
      assign arm_g = tx_event;
    end
    delay_timer #(.TW(TW), .RESTART(IS_PKT)) u_tmr (
      .clk(clk), .rst_n(rst_n), .unit_tick(unit_tick),
      .limit(lim_q[g]), .arm(arm_g), .expire(fire[g])
    );
  end

  assign rx_fire = fire[0] | fire[1];
  assign tx_fire = fire[2] | fire[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TIMERS; i++) lim_q[i] <= '0;
      thr_interval <= '0;
    end else if (reg_wr) begin
      for (int i = 0; i < NUM_TIMERS; i++)
        if (reg_sel == 3'(i)) lim_q[i] <= reg_wdata;
      if (reg_sel == SEL_THROTTLE) thr_interval <= reg_wdata;
    end
  end

  always_comb begin
    timer_bits           = '0;
    timer_bits[RX_CAUSE] = rx_fire;
    timer_bits[TX_CAUSE] = timer_bits[TX_CAUSE] | tx_fire;
  end

  assign in_bits    = (post_valid ? post_bits : '0) | timer_bits;
  assign cause_next = (cause_rd ? '0 : cause_q) | in_bits;
  assign mask_next  = (reg_wr && reg_sel == SEL_MASK) ? reg_wdata[NCAUSE-1:0] : mask_q;
  assign pend_next  = |(cause_next & mask_next);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q     <= '0;
      mask_q      <= '0;
      rx_wb_flush <= 1'b0;
      tx_wb_flush <= 1'b0;
    end else begin
      cause_q     <= cause_next;
      mask_q      <= mask_next;
      rx_wb_flush <= rx_fire;
      tx_wb_flush <= tx_fire;
    end
  end

  irq_throttle #(.TW(TW)) u_thr (
    .clk(clk), .rst_n(rst_n), .unit_tick(unit_tick),
    .interval(thr_interval), .pend_next(pend_next),
    .imm(post_valid && post_now), .irq(irq)
  );

  assign cause_rd_data = cause_q;
endmodule

// File: rtl/irq_moderator_chk.sv
module irq_moderator_chk #(
  parameter int NCAUSE   = 8,
  parameter int TW       = 16,
  parameter int TICK_DIV = 128,
  parameter int RX_CAUSE = 7,
  parameter int TX_CAUSE = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              post_valid,
  input logic [NCAUSE-1:0] post_bits,
  input logic              post_now,
  input logic              reg_wr,
  input logic              cause_rd,
  input logic              irq,
  input logic              rx_wb_flush,
  input logic              tx_wb_flush,
  input logic [NCAUSE-1:0] cause_q,
  input logic [NCAUSE-1:0] mask_q,
  input logic              rx_fire,
  input logic              tx_fire,
  input logic [TW-1:0]     thr_interval
);
  logic          irq_prev, imm_prev, seen;
  logic [31:0]   gap;
  logic [TW-1:0] cap;
  logic          rise;

  assign rise = irq && !irq_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_prev <= 1'b0;
      imm_prev <= 1'b0;
      seen     <= 1'b0;
      gap      <= '0;
      cap      <= '0;
    end else begin
      irq_prev <= irq;
      imm_prev <= post_valid && post_now;
      if (irq && !irq_prev) begin
        seen <= 1'b1;
        gap  <= '0;
      end else if (gap != 32'hFFFF_FFFF) begin
        gap  <= gap + 1'b1;
      end
      if (!irq && (irq_prev || !seen)) cap <= thr_interval;
      else if (irq && !irq_prev)       cap <= cap;
    end
  end

  // R3
  irq_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(cause_q & mask_q));

  // R4
  rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_rd && !post_valid && !rx_fire && !tx_fire) |=> (cause_q == '0 && !irq));

  // R6
  imm_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && post_now && |(post_bits & mask_q) && !reg_wr) |=> irq);

  // R7
  rx_flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wb_flush |-> cause_q[RX_CAUSE]);

  // R9
  tx_flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wb_flush |-> cause_q[TX_CAUSE]);

  // R5
  throttle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !imm_prev && seen && cap != '0) |->
      (gap >= (32'(cap) - 32'd1) * 32'(TICK_DIV) + 32'd1));
endmodule

bind irq_moderator irq_moderator_chk #(
  .NCAUSE(NCAUSE), .TW(TW), .TICK_DIV(TICK_DIV),
  .RX_CAUSE(RX_CAUSE), .TX_CAUSE(TX_CAUSE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_bits(post_bits),
  .post_now(post_now), .reg_wr(reg_wr), .cause_rd(cause_rd), .irq(irq),
  .rx_wb_flush(rx_wb_flush), .tx_wb_flush(tx_wb_flush), .cause_q(cause_q),
  .mask_q(mask_q), .rx_fire(rx_fire), .tx_fire(tx_fire),
  .thr_interval(thr_interval)
);

// File: tb/irq_moderator_tb.sv
module irq_moderator_tb;
  localparam int NCAUSE = 8;
  localparam int TW     = 16;
  localparam int DIV    = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              post_valid, post_now, rx_event, tx_event, reg_wr, cause_rd;
  logic [NCAUSE-1:0] post_bits;
  logic [2:0]        reg_sel;
  logic [TW-1:0]     reg_wdata;
  logic [NCAUSE-1:0] cause_rd_data;
  logic              irq, rx_wb_flush, tx_wb_flush;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, rx_fires = 0, tx_fires = 0, rx_last = 0, tx_last = 0, rise_last = 0;
  logic irq_prev = 1'b0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  irq_moderator #(.NCAUSE(NCAUSE), .TW(TW), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_bits(post_bits),
    .post_now(post_now), .rx_event(rx_event), .tx_event(tx_event),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cause_rd(cause_rd), .cause_rd_data(cause_rd_data), .irq(irq),
    .rx_wb_flush(rx_wb_flush), .tx_wb_flush(tx_wb_flush)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rx_wb_flush) begin rx_fires <= rx_fires + 1; rx_last <= cyc; end
    if (tx_wb_flush) begin tx_fires <= tx_fires + 1; tx_last <= cyc; end
    if (irq && !irq_prev) rise_last <= cyc;
    irq_prev <= irq;
  end

  function automatic logic exp_line(logic [NCAUSE-1:0] c, logic [NCAUSE-1:0] m);
    return |(c & m);
  endfunction

  function automatic bit in_window(int d, int n);
    return (d >= (n - 1) * DIV + 1) && (d <= n * DIV);
  endfunction

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [TW-1:0] v);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic post(logic [NCAUSE-1:0] b, logic now);
    post_valid = 1'b1; post_bits = b; post_now = now;
    step();
    post_valid = 1'b0; post_now = 1'b0;
  endtask

  task automatic rd_clear();
    cause_rd = 1'b1;
    step();
    cause_rd = 1'b0;
  endtask

  task automatic pulse_rx(output int e);
    rx_event = 1'b1; step(); e = cyc; rx_event = 1'b0;
  endtask

  task automatic pulse_tx(output int e);
    tx_event = 1'b1; step(); e = cyc; tx_event = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    logic [NCAUSE-1:0] ec, em;
    int e1, e2, f0, r1, r2;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; post_valid = 0; post_now = 0; post_bits = '0; rx_event = 0;
    tx_event = 0; reg_wr = 0; reg_sel = '0; reg_wdata = '0; cause_rd = 0;
    repeat (4) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 cause", cause_rd_data, 0);
    chk("R1 flush", rx_wb_flush | tx_wb_flush, 0);

    // R2/R3 random posts, reads and mask writes, throttle off
    ec = '0; em = '0;
    for (int i = 0; i < 400; i++) begin
      logic pv, rd, mw, nw;
      logic [NCAUSE-1:0] b, m;
      pv = 1'($urandom % 2); rd = ($urandom % 4) == 0; mw = ($urandom % 8) == 0;
      nw = 1'($urandom % 2);
      b = NCAUSE'($urandom); m = NCAUSE'($urandom);
      post_valid = pv; post_bits = b; post_now = nw; cause_rd = rd;
      rx_event = 1'($urandom % 2); tx_event = 1'($urandom % 2);
      reg_wr = mw; reg_sel = 3'd5; reg_wdata = TW'(m);
      if (rd) chk("R2 read value", cause_rd_data, ec);
      step();
      ec = (rd ? '0 : ec) | (pv ? b : '0);
      if (mw) em = m;
      chk("R3 line follows masked cause", irq, exp_line(ec, em));
      chk("R2 accumulate", cause_rd_data, ec);
    end
    post_valid = 0; post_now = 0; cause_rd = 0; reg_wr = 0; rx_event = 0; tx_event = 0;
    step();
    chk("R10 disabled timers never flush", rx_fires + tx_fires, 0);

    // R3 mask re-evaluation
    wr(3'd5, '0);
    rd_clear();
    post(8'h08, 1'b0);
    chk("R3 masked post keeps line low", irq, 0);
    wr(3'd5, 16'h0008);
    chk("R3 mask write raises", irq, 1);
    wr(3'd5, 16'h0000);
    chk("R3 mask write drops", irq, 0);

    // R2 read and post in the same cycle; R4 read drops line
    wr(3'd5, 16'h00FF);
    chk("R3 re-enable", irq, 1);
    cause_rd = 1'b1; post_valid = 1'b1; post_bits = 8'h04;
    chk("R2 read data before clear", cause_rd_data, 8'h08);
    step();
    cause_rd = 1'b0; post_valid = 1'b0;
    chk("R2 coincident post survives", cause_rd_data, 8'h04);
    rd_clear();
    chk("R4 read drops line", irq, 0);
    chk("R4 cause cleared", cause_rd_data, 0);
    wr(3'd5, '0);

    // R7 per-packet receive timer restarts
    wr(3'd0, 16'd3);
    f0 = rx_fires;
    pulse_rx(e1);
    repeat (5) step();
    pulse_rx(e2);
    repeat (20) step();
    chk("R7 one flush pulse", rx_fires - f0, 1);
    chk("R7 timed from last event", in_window(rx_last - e2, 3), 1);
    chk("R7 cause bit 7", cause_rd_data[7], 1);
    rd_clear();
    wr(3'd0, '0);

    // R8 absolute receive timer not restarted
    wr(3'd1, 16'd3);
    f0 = rx_fires;
    pulse_rx(e1);
    repeat (5) step();
    pulse_rx(e2);
    repeat (20) step();
    chk("R8 one flush pulse", rx_fires - f0, 1);
    chk("R8 timed from first event", in_window(rx_last - e1, 3), 1);
    chk("R8 cause bit 7", cause_rd_data[7], 1);
    rd_clear();
    wr(3'd1, '0);

    // R9 transmit timers
    wr(3'd2, 16'd2);
    f0 = tx_fires;
    pulse_tx(e1);
    repeat (15) step();
    chk("R9 pkt flush pulse", tx_fires - f0, 1);
    chk("R9 pkt window", in_window(tx_last - e1, 2), 1);
    chk("R9 cause bit 0", cause_rd_data, 8'h01);
    rd_clear();
    wr(3'd2, '0);
    wr(3'd3, 16'd4);
    f0 = tx_fires;
    pulse_tx(e1);
    repeat (2) step();
    pulse_tx(e2);
    repeat (20) step();
    chk("R9 abs flush pulse", tx_fires - f0, 1);
    chk("R9 abs timed from first event", in_window(tx_last - e1, 4), 1);
    rd_clear();
    wr(3'd3, '0);

    // R10 zero limit and cancel
    f0 = rx_fires + tx_fires;
    pulse_rx(e1);
    pulse_tx(e2);
    repeat (40) step();
    chk("R10 zero limit no flush", rx_fires + tx_fires - f0, 0);
    wr(3'd0, 16'd5);
    pulse_rx(e1);
    repeat (4) step();
    wr(3'd0, '0);
    repeat (40) step();
    chk("R10 cancel no flush", rx_fires + tx_fires - f0, 0);
    chk("R10 cancel no cause", cause_rd_data, 0);

    // R5 throttle and R6 immediate bypass
    wr(3'd4, 16'd5);
    wr(3'd5, 16'h00FF);
    post(8'h02, 1'b0);
    chk("R5 idle throttle raises next cycle", irq, 1);
    r1 = rise_last;
    rd_clear();
    chk("R4 read drops throttled line", irq, 0);
    post(8'h04, 1'b0);
    chk("R5 held off while interval runs", irq, 0);
    repeat (3) step();
    chk("R5 still held", irq, 0);
    for (int k = 0; k < 40 && !irq; k++) step();
    step();
    r2 = rise_last;
    chk("R5 rises after interval", irq, 1);
    chk("R5 spacing window", (r2 - r1 >= 4 * DIV + 2) && (r2 - r1 <= 5 * DIV + 2), 1);
    rd_clear();
    post(8'h10, 1'b1);
    chk("R6 immediate bypasses throttle", irq, 1);
    rd_clear();

    done = 1'b1;
    finish_run();
  end
endmodule